// File: doc/BRIEF.md
# TPM Locality Claim Sequencer

This block performs the start-up handshake that gives the host ownership of locality zero on a TPM-style target. It sits in front of a transaction engine that carries register reads and writes over the serial link. For each step the block issues one request carrying an address, a direction, a byte length and write data. It then waits for the engine's response and inspects the returned register contents before moving on.

A start pulse launches the sequence, which proceeds as follows:

- The identifier register is fetched.
- The access register is examined. A locality left active by an earlier owner is released and the register is re-examined.
- Use of the locality is requested and the grant is confirmed.
- The status register's interface family field is verified.
- The revision byte is fetched.

The block finishes with a one-cycle done pulse and an error code. On success it publishes the vendor, device and revision identifiers. On failure the code names the failing check, or the engine fault.

Top module: `tpm_loc_claim`

## Requirements
- R1: After reset the block is idle, with `req_valid`, `busy` and `done` low, `err_code` 0, and all identifier outputs 0.
- R2: A `start` pulse while idle sets `busy` and, on the cycle after `start` is sampled, raises a 4-byte read (`req_write` 0) of window base + 0xF00. A `start` while busy has no effect.
- R3: Each step raises `req_valid` for exactly one cycle. The next request follows only after `rsp_valid` answers the current one. A `rsp_valid` arriving while no request is outstanding is ignored.
- R4: The access register (base + 0x00) is read as one byte. If bit 5 (active) of that byte is set, a one-byte write of 0x20 to the access register follows, then another one-byte read of it. Every write the block issues is one byte to the access register.
- R5: The examined access byte (the re-read one if a release happened), with bit 0 masked, must equal 0x80 (valid bit 7 alone); otherwise the sequence ends with `err_code` 2.
- R6: Next, 0x02 (request-use bit 1) is written to the access register and the register is read back. With bit 0 masked the value must be 0xA0, or the sequence ends with `err_code` 3.
- R7: The status register (base + 0x18) is then read as 4 bytes. Bits 27:26 must equal 2'b01, or the sequence ends with `err_code` 4.
- R8: Finally, one byte is read from base + 0xF04 and the sequence ends with `err_code` 0. `vendor_id` is identifier bits 15:0, `device_id` is bits 31:16, and `revision` is `rsp_rdata[7:0]` of the last read. These outputs change only on a successful finish.
- R9: A response with `rsp_err` high ends the sequence at once with `err_code` 1, and no further request is issued.
- R10: Every finish returns the block to idle and pulses `done` for one cycle, one cycle after the final response is sampled. `err_code` changes only together with `done` and holds until the next finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted while idle |
| req_valid | output | 1 | One-cycle request strobe to the transaction engine |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 24 | Register address |
| req_len | output | 7 | Transfer length in bytes |
| req_wdata | output | 8 | Write data byte |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_err | input | 1 | Engine reports a failed transaction |
| rsp_rdata | input | 32 | Read data, little-endian byte order |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | 0 ok, 1 engine fault, 2 bad initial access state, 3 claim refused, 4 wrong family |
| vendor_id | output | 16 | Vendor identifier from the last successful run |
| device_id | output | 16 | Device identifier from the last successful run |
| revision | output | 8 | Revision byte from the last successful run |

## Verification
The first request is due in the cycle right after `start` is sampled. Each later request appears in the cycle after the response to the previous one is sampled. `done` with its error code is due one cycle after the final response. The engine model in the bench samples requests and drives responses on the falling clock edge, and responds one to three cycles after each request. It logs every request for comparison against a request list and an error code that the bench derives from the access, status and fault-injection settings of each run. The bench polls `done` on falling edges and checks that the pulse has cleared one cycle later.

// File: rtl/tpm_loc_claim.sv
module tpm_loc_claim #(
  parameter logic [23:0] WIN_BASE = 24'hD40000,
  parameter logic [23:0] ACC_OFS  = 24'h000000,
  parameter logic [23:0] STS_OFS  = 24'h000018,
  parameter logic [23:0] ID_OFS   = 24'h000F00,
  parameter logic [23:0] REV_OFS  = 24'h000F04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        req_valid,
  output logic        req_write,
  output logic [23:0] req_addr,
  output logic [6:0]  req_len,
  output logic [7:0]  req_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [31:0] rsp_rdata,
  output logic        busy,
  output logic        done,
  output logic [2:0]  err_code,
  output logic [15:0] vendor_id,
  output logic [15:0] device_id,
  output logic [7:0]  revision
);

  localparam logic [7:0] BIT_VALID  = 8'h80;
  localparam logic [7:0] BIT_ACTIVE = 8'h20;
  localparam logic [7:0] BIT_ASK    = 8'h02;
  localparam logic [7:0] LOW_MASK   = 8'hFE;
  localparam logic [1:0] FAMILY_OK  = 2'b01;

  localparam logic [2:0] E_NONE   = 3'd0;
  localparam logic [2:0] E_ENGINE = 3'd1;
  localparam logic [2:0] E_STATE  = 3'd2;
  localparam logic [2:0] E_CLAIM  = 3'd3;
  localparam logic [2:0] E_FAMILY = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_PEEK, ST_DROP, ST_REPEEK,
    ST_ASK, ST_CONFIRM, ST_STS, ST_REV
  } step_t;

  step_t       st;
  logic        pend;
  logic [31:0] id_q;
  logic [7:0]  acc_m;

  assign busy      = (st != ST_IDLE);
  assign req_valid = busy && !pend;
  assign acc_m     = rsp_rdata[7:0] & LOW_MASK;

  always_comb begin
    req_write = 1'b0;
    req_len   = 7'd1;
    req_wdata = 8'h00;
    req_addr  = WIN_BASE + ACC_OFS;
    case (st)
      ST_ID:   begin req_addr = WIN_BASE + ID_OFS;  req_len = 7'd4; end
      ST_STS:  begin req_addr = WIN_BASE + STS_OFS; req_len = 7'd4; end
      ST_REV:  req_addr = WIN_BASE + REV_OFS;
      ST_DROP: begin req_write = 1'b1; req_wdata = BIT_ACTIVE; end
      ST_ASK:  begin req_write = 1'b1; req_wdata = BIT_ASK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      done      <= 1'b0;
      err_code  <= E_NONE;
      id_q      <= '0;
      vendor_id <= '0;
      device_id <= '0;
      revision  <= '0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        pend <= 1'b0;
        if (start) st <= ST_ID;
      end else if (!pend) begin
        pend <= 1'b1;
      end else if (rsp_valid) begin
        pend <= 1'b0;
        if (rsp_err) begin
          st <= ST_IDLE; done <= 1'b1; err_code <= E_ENGINE;
        end else begin
          case (st)
            ST_ID: begin
              id_q <= rsp_rdata;
              st   <= ST_PEEK;
            end
            ST_PEEK: begin
              if ((rsp_rdata[7:0] & BIT_ACTIVE) != 8'h00) st <= ST_DROP;
              else if (acc_m == BIT_VALID) st <= ST_ASK;
              else begin st <= ST_IDLE; done <= 1'b1; err_code <= E_STATE; end
            end
            ST_DROP: st <= ST_REPEEK;
            ST_REPEEK: begin
              if (acc_m == BIT_VALID) st <= ST_ASK;
              else begin st <= ST_IDLE; done <= 1'b1; err_code <= E_STATE; end
            end
            ST_ASK: st <= ST_CONFIRM;
            ST_CONFIRM: begin
              if (acc_m == (BIT_VALID | BIT_ACTIVE)) st <= ST_STS;
              else begin st <= ST_IDLE; done <= 1'b1; err_code <= E_CLAIM; end
            end
            ST_STS: begin
              if (rsp_rdata[27:26] == FAMILY_OK) st <= ST_REV;
              else begin st <= ST_IDLE; done <= 1'b1; err_code <= E_FAMILY; end
            end
            ST_REV: begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              err_code  <= E_NONE;
              vendor_id <= id_q[15:0];
              device_id <= id_q[31:16];
              revision  <= rsp_rdata[7:0];
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tpm_loc_claim_chk.sv
module tpm_loc_claim_chk #(
  parameter logic [23:0] WIN_BASE = 24'hD40000,
  parameter logic [23:0] ACC_OFS  = 24'h000000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        req_valid,
  input logic        req_write,
  input logic [23:0] req_addr,
  input logic [6:0]  req_len,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        done,
  input logic [2:0]  err_code
);

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && req_valid));

  // R3
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R4
  write_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_len == 7'd1 && req_addr == WIN_BASE + ACC_OFS));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_valid && rsp_valid && rsp_err) |=> (!busy && done && err_code == 3'd1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err_code));

endmodule

bind tpm_loc_claim tpm_loc_claim_chk #(.WIN_BASE(WIN_BASE), .ACC_OFS(ACC_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_len(req_len), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .done(done), .err_code(err_code)
);

// File: tb/sim_tpm_loc_claim.sv
`timescale 1ns/1ps
module sim_tpm_loc_claim;
  localparam logic [23:0] BASE = 24'hD40000;
  localparam logic [23:0] A_ACC = BASE + 24'h000, A_STS = BASE + 24'h018;
  localparam logic [23:0] A_ID = BASE + 24'hF00, A_REV = BASE + 24'hF04;

  logic clk = 0, rst_n = 0, start = 0;
  logic rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_rdata = 0;
  logic req_valid, req_write, busy, done;
  logic [23:0] req_addr;
  logic [6:0] req_len;
  logic [7:0] req_wdata, revision;
  logic [2:0] err_code;
  logic [15:0] vendor_id, device_id;

  tpm_loc_claim u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .busy(busy), .done(done), .err_code(err_code),
    .vendor_id(vendor_id), .device_id(device_id), .revision(revision)
  );

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // target model
  logic [7:0]  acc_seq [0:2];
  int          acc_idx = 0, err_at = -1, lat = 1, wait_cnt = 0, n_log = 0;
  logic [31:0] sts_v = 0, id_v = 0, pend_data = 0;
  logic [7:0]  rid_v = 0;
  bit          outst = 0, pend_err = 0, spur_req = 0;
  logic [23:0] lg_addr [0:15];
  logic        lg_wr   [0:15];
  logic [6:0]  lg_len  [0:15];
  logic [7:0]  lg_wd   [0:15];

  always @(negedge clk) begin
    rsp_valid = 0;
    rsp_err = 0;
    if (spur_req) begin
      rsp_valid = 1; rsp_err = 1; spur_req = 0;
    end else if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        rsp_valid = 1; rsp_err = pend_err; rsp_rdata = pend_data; outst = 0;
      end
    end
    if (req_valid && !outst) begin
      if (n_log < 16) begin
        lg_addr[n_log] = req_addr; lg_wr[n_log] = req_write;
        lg_len[n_log] = req_len; lg_wd[n_log] = req_wdata;
      end
      pend_err = (n_log == err_at);
      pend_data = 32'hDEADBEEF;
      if (!req_write) begin
        if (req_addr == A_ACC) begin
          pend_data = {24'h5A5A5A, acc_seq[acc_idx]};
          if (acc_idx < 2) acc_idx++;
        end else if (req_addr == A_STS) pend_data = sts_v;
        else if (req_addr == A_ID) pend_data = id_v;
        else if (req_addr == A_REV) pend_data = {24'hA5A5A5, rid_v};
      end
      n_log++;
      outst = 1;
      wait_cnt = lat;
    end
  end

  // expected request stream
  logic [23:0] ex_addr [0:15];
  logic        ex_wr   [0:15];
  logic [6:0]  ex_len  [0:15];
  logic [7:0]  ex_wd   [0:15];
  int n_exp = 0;
  logic [2:0] exp_code = 0;

  task automatic push(input logic [23:0] a, input logic w, input logic [6:0] l, input logic [7:0] d);
    ex_addr[n_exp] = a; ex_wr[n_exp] = w; ex_len[n_exp] = l; ex_wd[n_exp] = d;
    n_exp++;
  endtask

  task automatic build_exp(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
                           input logic [31:0] sts, input int eat);
    logic [7:0] a;
    n_exp = 0; exp_code = 0;
    push(A_ID, 0, 4, 0);   if (eat == n_exp - 1) begin exp_code = 1; return; end
    push(A_ACC, 0, 1, 0);  if (eat == n_exp - 1) begin exp_code = 1; return; end
    a = a0;
    if (a0[5]) begin
      push(A_ACC, 1, 1, 8'h20); if (eat == n_exp - 1) begin exp_code = 1; return; end
      push(A_ACC, 0, 1, 0);     if (eat == n_exp - 1) begin exp_code = 1; return; end
      a = a1;
    end
    if ((a & 8'hFE) != 8'h80) begin exp_code = 2; return; end
    push(A_ACC, 1, 1, 8'h02); if (eat == n_exp - 1) begin exp_code = 1; return; end
    push(A_ACC, 0, 1, 0);     if (eat == n_exp - 1) begin exp_code = 1; return; end
    if ((a2 & 8'hFE) != 8'hA0) begin exp_code = 3; return; end
    push(A_STS, 0, 4, 0);     if (eat == n_exp - 1) begin exp_code = 1; return; end
    if (sts[27:26] != 2'b01) begin exp_code = 4; return; end
    push(A_REV, 0, 1, 0);     if (eat == n_exp - 1) begin exp_code = 1; return; end
  endtask

  int case_no = 0;
  logic [15:0] pv_vend = 0, pv_dev = 0;
  logic [7:0]  pv_rev = 0;

  task automatic run_case(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
                          input logic [31:0] sts, input int eat, input bit restart, input bit spur);
    int cyc;
    string tg;
    if (a0[5]) begin acc_seq[0] = a0; acc_seq[1] = a1; acc_seq[2] = a2; end
    else begin acc_seq[0] = a0; acc_seq[1] = a2; acc_seq[2] = a2; end
    acc_idx = 0; sts_v = sts; err_at = eat; lat = (case_no % 3) + 1;
    id_v = {8'hC0, 8'(case_no), 16'h1D00 + 16'(case_no)};
    rid_v = 8'(case_no * 7 + 3);
    n_log = 0;
    case_no++;
    build_exp(a0, a1, a2, sts, eat);
    if (spur) begin
      spur_req = 1;
      repeat (3) @(negedge clk);
      chk(!busy && !done && n_log == 0, "R3 stray response while idle", {30'd0, busy, done}, 0);
    end
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(req_valid && !req_write && req_addr == A_ID && req_len == 7'd4,
        "R2 first request one cycle after start", {req_valid, req_write, req_len, req_addr},
        {1'b1, 1'b0, 7'd4, A_ID});
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
      start = (restart && cyc == 3);
    end
    start = 0;
    chk(done, "R10 done reached", {31'd0, done}, 1);
    case (exp_code)
      3'd0: tg = "R8 success code";
      3'd1: tg = "R9 engine fault code";
      3'd2: tg = "R5 access state code";
      3'd3: tg = "R6 claim code";
      default: tg = "R7 family code";
    endcase
    chk(err_code == exp_code, tg, {29'd0, err_code}, {29'd0, exp_code});
    chk(n_log == n_exp, "R3 request count", n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      chk(lg_addr[i] == ex_addr[i] && lg_wr[i] == ex_wr[i] && lg_len[i] == ex_len[i],
          "R4 request address/direction/length", {lg_wr[i], lg_len[i], lg_addr[i]},
          {ex_wr[i], ex_len[i], ex_addr[i]});
      if (ex_wr[i])
        chk(lg_wd[i] == ex_wd[i], "R6 write data byte", {24'd0, lg_wd[i]}, {24'd0, ex_wd[i]});
    end
    if (exp_code == 0) begin
      pv_vend = id_v[15:0]; pv_dev = id_v[31:16]; pv_rev = rid_v;
    end
    chk(vendor_id == pv_vend && device_id == pv_dev && revision == pv_rev,
        "R8 published identifiers", {vendor_id, device_id} ^ {24'd0, revision},
        {pv_vend, pv_dev} ^ {24'd0, pv_rev});
    @(negedge clk);
    chk(!done && !busy, "R10 single done pulse, idle", {30'd0, done, busy}, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] l0 [0:7];
    logic [7:0] l1 [0:3];
    logic [7:0] l2 [0:3];
    l0 = '{8'h80, 8'h81, 8'hA0, 8'hA1, 8'h00, 8'h20, 8'h82, 8'hFF};
    l1 = '{8'h80, 8'h81, 8'hA0, 8'h00};
    l2 = '{8'hA0, 8'hA1, 8'h80, 8'hE0};
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!req_valid && !busy && !done && err_code == 0, "R1 reset control outputs",
        {28'd0, req_valid, busy, done, |err_code}, 0);
    chk(vendor_id == 0 && device_id == 0 && revision == 0, "R1 reset identifiers",
        {vendor_id, device_id} | {24'd0, revision}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int i0 = 0; i0 < 8; i0++)
      for (int i1 = 0; i1 < 4; i1++)
        for (int i2 = 0; i2 < 4; i2++)
          for (int f = 0; f < 4; f++)
            if (l0[i0][5] || i1 == 0)
              run_case(l0[i0], l1[i1], l2[i2], {4'h5, 2'(f), 26'h1234567}, -1, 0, 0);
    // R9 engine fault at each step of the longest path
    for (int e = 0; e < 8; e++)
      run_case(8'hA1, 8'h81, 8'hA1, 32'h04000000, e, 0, 0);
    // R2 start while busy, R3 stray response while idle
    run_case(8'h80, 8'h80, 8'hA0, 32'h07FF0000, -1, 1, 0);
    run_case(8'hA0, 8'h80, 8'hA0, 32'h04000000, -1, 0, 1);
    summary();
  end
endmodule